// File: doc/BRIEF.md
# Endpoint Queue Head Sequencer

This block services a ring of per-endpoint queue heads kept in word-addressed memory. Every queue head carries the fixed traits of one endpoint (its largest packet size) and a working copy, the overlay, of the transfer descriptor now in progress. On each visit the sequencer fetches the queue head, does at most one piece of work for it, writes the outcome back, and then follows the forward pointer to the next queue head in the ring.

Each queue head can be in one of four conditions, and the visit depends on which:
- **Active:** one bus transaction goes to an external transaction engine. The bytes moved and the error flags come back and are folded into the overlay token.
- **Idle, with a descriptor waiting:** that descriptor is copied into the overlay, so the queue moves forward with no help from software.
- **Halted:** the queue head is left untouched.
- **Idle, with no descriptor waiting:** the queue head is left untouched.

When a descriptor finishes, its token, including any error bits gathered along the way, is also written back into the descriptor itself.

Memory traffic uses 32-bit word reads and writes with a request/acknowledge handshake. The transaction engine uses a request/done handshake.

Top module: `qh_sequencer`

## Requirements

- R1: Each visit reads five words of the queue head at word offsets 0 to 4, in that order:
  - offset 0: forward pointer;
  - offset 1: maximum packet size in bits 15:0;
  - offset 2: current descriptor pointer;
  - offset 3: overlay next-descriptor pointer;
  - offset 4: overlay token.

  After the visit, the next queue head is the one at the address in word 0, so the ring is circular. The first queue head visited after `run` rises is `list_head`.
- R2: A memory request stays asserted, with address, write enable and write data unchanged, until `mem_ack`. Memory and the transaction engine are never requested in the same cycle.
- R3: A queue head that is neither active nor halted, and whose overlay next pointer has bit 0 (terminate) clear, loads that descriptor. The descriptor has its next pointer at offset 0 and its token at offset 1. The load reads those two words, then writes:
  - queue head offset 2 = the descriptor address;
  - offset 3 = the descriptor's next pointer;
  - offset 4 = the descriptor's token.

  No transaction is issued on that visit.
- R4: An active queue head issues exactly one transaction per visit. `xact_len` is the smaller of the maximum packet size and the remaining byte count. Remaining bytes are held in token bits 31:16, and the active bit is token bit 7. `xact_req` stays high with `xact_len` stable until `xact_done`.
- R5: After every transaction the overlay token is written back. Its remaining count drops by the bytes returned, and saturates at zero.
- R6: The error flags `xact_err` are bit 0 transaction error, bit 1 buffer error and bit 2 babble. They are ORed into token bits 3, 5 and 4 respectively, and stay set until the descriptor completes.
- R7: A descriptor completes in any of these cases:
  - its remaining count reaches zero;
  - a short transfer arrives with no error;
  - a fatal error occurs.

  On completion the active bit is cleared and the final token is also written to descriptor offset 1 (current descriptor pointer + 1).
- R8: Babble and transaction error are fatal. A fatal error sets the halted bit (token bit 6) and clears the active bit.
- R9: A halted queue head causes no transaction and no memory write, and its descriptor pointer does not move.
- R10: An idle queue head whose overlay next pointer has the terminate bit set causes no transaction and no memory write.
- R11: With the default `BUFERR_HALTS = 0`, a buffer error alone does not complete the descriptor. The transaction is retried on later visits.
- R12: During reset neither `mem_req` nor `xact_req` is asserted.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Keep walking the ring while high |
| list_head | input | AW | Word address of the first queue head |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access accepted / data valid |
| xact_req | output | 1 | Transaction request |
| xact_len | output | 16 | Bytes offered for this transaction |
| xact_done | input | 1 | Transaction finished |
| xact_bytes | input | 16 | Bytes actually moved |
| xact_err | input | 3 | {babble, buffer error, transaction error} |

## Verification

The bench builds the block with `AW = 8`, so a three-entry ring and three chained descriptors fit in a 256-word memory model. With these values:
- Pointer bit 0 can carry the terminate flag.
- The halted and idle queue heads show up on every lap.

`BUFERR_HALTS` stays 0, which makes a buffer-error retry reachable. That retry leaves a sticky error bit that only surfaces in the completed descriptor. Maximum packet size 8 against a 20-byte descriptor forces several transactions per descriptor, and a short final chunk exercises the length clipping.

// File: rtl/qhs_pkg.sv
package qhs_pkg;
   localparam int TOK_REM_LSB = 16;
   localparam int ST_ACTIVE   = 7;
   localparam int ST_HALTED   = 6;
   localparam int ST_BUFERR   = 5;
   localparam int ST_BABBLE   = 4;
   localparam int ST_XACTERR  = 3;
   localparam int ERR_XACT    = 0;
   localparam int ERR_BUF     = 1;
   localparam int ERR_BABBLE  = 2;

   typedef enum logic [3:0] {
      S_IDLE, S_RD_FWD, S_RD_EP, S_RD_CUR, S_RD_OVN, S_RD_TOK, S_DECIDE,
      S_LD_NXT, S_LD_TOK, S_WR_CUR, S_WR_NXT, S_XREQ, S_WR_OTOK, S_WR_QTD, S_ADV
   } seq_state_t;
endpackage

// File: rtl/qhs_len_clip.sv
module qhs_len_clip #(
   parameter int LW = 16
) (
   input  logic [LW-1:0] max_pkt,
   input  logic [LW-1:0] remain,
   output logic [LW-1:0] len
);
   always_comb len = (remain < max_pkt) ? remain : max_pkt;
endmodule

// File: rtl/qhs_status_merge.sv
module qhs_status_merge
   import qhs_pkg::*;
#(
   parameter int LW           = 16,
   parameter bit BUFERR_HALTS = 1'b0
) (
   input  logic [31:0]   tok_in,
   input  logic [LW-1:0] req_len,
   input  logic [LW-1:0] bytes,
   input  logic [2:0]    err,
   output logic [31:0]   tok_out,
   output logic          complete
);
   logic [LW-1:0] rem, new_rem;
   logic          fatal, short_pkt, any_err;

   generate
      if (BUFERR_HALTS) begin : g_buf_fatal
         always_comb fatal = err[ERR_BABBLE] | err[ERR_XACT] | err[ERR_BUF];
      end else begin : g_buf_retry
         always_comb fatal = err[ERR_BABBLE] | err[ERR_XACT];
      end
   endgenerate

   always_comb begin
      rem       = tok_in[TOK_REM_LSB +: LW];
      new_rem   = (bytes >= rem) ? '0 : rem - bytes;
      short_pkt = bytes < req_len;
      any_err   = |err;
      complete  = fatal | (new_rem == '0) | (short_pkt & ~any_err);
      tok_out   = tok_in;
      tok_out[TOK_REM_LSB +: LW] = new_rem;
      tok_out[ST_BABBLE]  = tok_in[ST_BABBLE]  | err[ERR_BABBLE];
      tok_out[ST_BUFERR]  = tok_in[ST_BUFERR]  | err[ERR_BUF];
      tok_out[ST_XACTERR] = tok_in[ST_XACTERR] | err[ERR_XACT];
      tok_out[ST_ACTIVE]  = ~complete;
      tok_out[ST_HALTED]  = fatal;
   end
endmodule

// File: rtl/qh_sequencer.sv
module qh_sequencer
   import qhs_pkg::*;
#(
   parameter int AW           = 16,
   parameter bit BUFERR_HALTS = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [AW-1:0] list_head,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata,
   input  logic          mem_ack,
   output logic          xact_req,
   output logic [15:0]   xact_len,
   input  logic          xact_done,
   input  logic [15:0]   xact_bytes,
   input  logic [2:0]    xact_err
);
   localparam int LW = 16;

   generate
      if (AW < 4 || AW > 32) begin : g_bad_aw
         $error("qh_sequencer: AW must lie in 4..32");
      end
   endgenerate

   seq_state_t    state;
   logic [AW-1:0] qh_addr;
   logic [31:0]   fwd_ptr, cur_ptr, ovl_next, ld_next, tok;
   logic [LW-1:0] max_pkt;
   logic          fin;
   logic [31:0]   merged_tok;
   logic          merged_done;
   logic [LW-1:0] clip_len;

   qhs_len_clip #(.LW(LW)) u_clip (
      .max_pkt (max_pkt),
      .remain  (tok[TOK_REM_LSB +: LW]),
      .len     (clip_len)
   );

   qhs_status_merge #(.LW(LW), .BUFERR_HALTS(BUFERR_HALTS)) u_merge (
      .tok_in   (tok),
      .req_len  (clip_len),
      .bytes    (xact_bytes),
      .err      (xact_err),
      .tok_out  (merged_tok),
      .complete (merged_done)
   );

   always_comb begin
      mem_req   = 1'b1;
      mem_we    = 1'b0;
      mem_addr  = qh_addr;
      mem_wdata = '0;
      unique case (state)
         S_RD_FWD:  mem_addr = qh_addr;
         S_RD_EP:   mem_addr = qh_addr + AW'(1);
         S_RD_CUR:  mem_addr = qh_addr + AW'(2);
         S_RD_OVN:  mem_addr = qh_addr + AW'(3);
         S_RD_TOK:  mem_addr = qh_addr + AW'(4);
         S_LD_NXT:  mem_addr = ovl_next[AW-1:0];
         S_LD_TOK:  mem_addr = ovl_next[AW-1:0] + AW'(1);
         S_WR_CUR:  begin mem_we = 1'b1; mem_addr = qh_addr + AW'(2); mem_wdata = cur_ptr; end
         S_WR_NXT:  begin mem_we = 1'b1; mem_addr = qh_addr + AW'(3); mem_wdata = ld_next; end
         S_WR_OTOK: begin mem_we = 1'b1; mem_addr = qh_addr + AW'(4); mem_wdata = tok; end
         S_WR_QTD:  begin mem_we = 1'b1; mem_addr = cur_ptr[AW-1:0] + AW'(1); mem_wdata = tok; end
         default:   mem_req = 1'b0;
      endcase
   end

   always_comb begin
      xact_req = (state == S_XREQ);
      xact_len = clip_len;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         qh_addr  <= '0;
         fwd_ptr  <= '0;
         cur_ptr  <= '0;
         ovl_next <= '0;
         ld_next  <= '0;
         tok      <= '0;
         max_pkt  <= '0;
         fin      <= 1'b0;
      end else begin
         unique case (state)
            S_IDLE: if (run) begin
               qh_addr <= list_head;
               state   <= S_RD_FWD;
            end
            S_RD_FWD: if (mem_ack) begin fwd_ptr  <= mem_rdata;          state <= S_RD_EP;  end
            S_RD_EP:  if (mem_ack) begin max_pkt  <= mem_rdata[LW-1:0];  state <= S_RD_CUR; end
            S_RD_CUR: if (mem_ack) begin cur_ptr  <= mem_rdata;          state <= S_RD_OVN; end
            S_RD_OVN: if (mem_ack) begin ovl_next <= mem_rdata;          state <= S_RD_TOK; end
            S_RD_TOK: if (mem_ack) begin tok      <= mem_rdata;          state <= S_DECIDE; end
            S_DECIDE: begin
               if (tok[ST_HALTED])     state <= S_ADV;
               else if (tok[ST_ACTIVE]) state <= S_XREQ;
               else if (ovl_next[0])    state <= S_ADV;
               else                     state <= S_LD_NXT;
            end
            S_LD_NXT: if (mem_ack) begin ld_next <= mem_rdata; state <= S_LD_TOK; end
            S_LD_TOK: if (mem_ack) begin
               tok     <= mem_rdata;
               cur_ptr <= ovl_next;
               fin     <= 1'b0;
               state   <= S_WR_CUR;
            end
            S_WR_CUR: if (mem_ack) state <= S_WR_NXT;
            S_WR_NXT: if (mem_ack) state <= S_WR_OTOK;
            S_XREQ: if (xact_done) begin
               tok   <= merged_tok;
               fin   <= merged_done;
               state <= S_WR_OTOK;
            end
            S_WR_OTOK: if (mem_ack) state <= fin ? S_WR_QTD : S_ADV;
            S_WR_QTD:  if (mem_ack) state <= S_ADV;
            S_ADV: begin
               qh_addr <= fwd_ptr[AW-1:0];
               state   <= run ? S_RD_FWD : S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/qhs_checker.sv
module qhs_checker #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [31:0]   mem_wdata,
   input logic          mem_ack,
   input logic          xact_req,
   input logic [15:0]   xact_len,
   input logic          xact_done
);
   p_one_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && xact_req));

   p_mem_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   p_xact_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xact_req && !xact_done) |=> (xact_req && $stable(xact_len)));

   p_writeback_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (xact_req && xact_done) |=> (!xact_req && mem_req && mem_we));
endmodule

bind qh_sequencer qhs_checker #(.AW(AW)) u_qhs_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack),
   .xact_req  (xact_req),
   .xact_len  (xact_len),
   .xact_done (xact_done)
);

// File: tb/qh_sequencer_tb_top.sv
module qh_sequencer_tb_top;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run = 1'b0;
   logic [AW-1:0] list_head = 8'h10;
   logic          mem_req, mem_we, mem_ack;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata, mem_rdata;
   logic          xact_req, xact_done;
   logic [15:0]   xact_len, xact_bytes;
   logic [2:0]    xact_err;

   always #2 clk = ~clk;   // 250 MHz

   qh_sequencer #(.AW(AW), .BUFERR_HALTS(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .run(run), .list_head(list_head),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .xact_req(xact_req), .xact_len(xact_len), .xact_done(xact_done),
      .xact_bytes(xact_bytes), .xact_err(xact_err)
   );

   typedef struct { logic [7:0] addr; logic [31:0] data; string tag; } wr_item_t;
   typedef struct { logic [15:0] len; logic [15:0] bytes; logic [2:0] err; string tag; } xa_item_t;

   wr_item_t    exp_wr[$];
   xa_item_t    exp_xa[$];
   xa_item_t    resp_q[$];
   logic [31:0] mem [256];
   logic [7:0]  rd_log [10];
   int          rd_cnt = 0;
   int          total = 0;
   int          bad = 0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push_wr(input logic [7:0] a, input logic [31:0] d, input string tag);
      wr_item_t it;
      it.addr = a; it.data = d; it.tag = tag;
      exp_wr.push_back(it);
   endtask

   task automatic push_xa(input logic [15:0] len, input logic [15:0] by, input logic [2:0] e, input string tag);
      xa_item_t it;
      it.len = len; it.bytes = by; it.err = e; it.tag = tag;
      exp_xa.push_back(it);
      resp_q.push_back(it);
   endtask

   // memory model: one-cycle acknowledge
   always @(posedge clk) begin
      if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_we) mem[mem_addr] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr];
      end else begin
         mem_ack <= 1'b0;
      end
   end

   // transaction engine model
   always @(posedge clk) begin
      if (xact_req && !xact_done) begin
         xact_done <= 1'b1;
         if (resp_q.size() > 0) begin
            xact_bytes <= resp_q[0].bytes;
            xact_err   <= resp_q[0].err;
            resp_q.pop_front();
         end else begin
            xact_bytes <= '0;
            xact_err   <= '0;
         end
      end else begin
         xact_done <= 1'b0;
      end
   end

   // monitor: compares results away from the active edge
   always @(negedge clk) begin
      if (rst_n && mem_req && mem_ack) begin
         if (mem_we) begin
            if (exp_wr.size() == 0) begin
               total++; bad++;
               $display("FAIL R9/R10 unexpected write actual=%h@%h expected=none", mem_wdata, mem_addr);
            end else begin
               check({exp_wr[0].tag, " addr"}, {24'h0, mem_addr}, {24'h0, exp_wr[0].addr});
               check({exp_wr[0].tag, " data"}, mem_wdata, exp_wr[0].data);
               exp_wr.pop_front();
            end
         end else if (rd_cnt < 10) begin
            rd_log[rd_cnt] = mem_addr;
            rd_cnt++;
         end
      end
      if (rst_n && xact_req && xact_done) begin
         if (exp_xa.size() == 0) begin
            total++; bad++;
            $display("FAIL R9 unexpected transaction actual=len %0d expected=none", xact_len);
         end else begin
            check({exp_xa[0].tag, " xact_len"}, {16'h0, xact_len}, {16'h0, exp_xa[0].len});
            exp_xa.pop_front();
         end
      end
   end

   initial begin
      logic [7:0] exp_rd [10];
      int cyc;
      mem_ack = 1'b0; mem_rdata = '0;
      xact_done = 1'b0; xact_bytes = '0; xact_err = '0;
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
      // QH0 at 0x10: max packet 8, next descriptor 0x40, idle
      mem[8'h10] = 32'h20; mem[8'h11] = 32'd8; mem[8'h13] = 32'h40;
      // QH1 at 0x20: idle, terminate set in next pointer
      mem[8'h20] = 32'h30; mem[8'h21] = 32'd64; mem[8'h23] = 32'h1;
      // QH2 at 0x30: halted (and active)
      mem[8'h30] = 32'h10; mem[8'h31] = 32'd64; mem[8'h32] = 32'h50;
      mem[8'h33] = 32'h52; mem[8'h34] = 32'h000400C0;
      // descriptors A, B, C
      mem[8'h40] = 32'h42; mem[8'h41] = 32'h00140080;
      mem[8'h42] = 32'h44; mem[8'h43] = 32'h00080080;
      mem[8'h44] = 32'h01; mem[8'h45] = 32'h00100080;

      // scoreboard expectations, in issue order
      push_wr(8'h12, 32'h40, "R3 load A cur");
      push_wr(8'h13, 32'h42, "R3 load A next");
      push_wr(8'h14, 32'h00140080, "R3 load A token");
      push_xa(16'd8, 16'd8, 3'b000, "R4 A first");
      push_wr(8'h14, 32'h000C0080, "R5 remaining drop");
      push_xa(16'd8, 16'd0, 3'b010, "R11 buffer error retry");
      push_wr(8'h14, 32'h000C00A0, "R6 R11 sticky buffer error");
      push_xa(16'd8, 16'd8, 3'b000, "R4 A third");
      push_wr(8'h14, 32'h000400A0, "R6 sticky kept");
      push_xa(16'd4, 16'd4, 3'b000, "R4 clip to remaining");
      push_wr(8'h14, 32'h00000020, "R7 zero remaining overlay");
      push_wr(8'h41, 32'h00000020, "R7 writeback A");
      push_wr(8'h12, 32'h42, "R3 load B cur");
      push_wr(8'h13, 32'h44, "R3 load B next");
      push_wr(8'h14, 32'h00080080, "R3 load B token");
      push_xa(16'd8, 16'd3, 3'b000, "R7 short packet");
      push_wr(8'h14, 32'h00050000, "R7 short overlay");
      push_wr(8'h43, 32'h00050000, "R7 writeback B");
      push_wr(8'h12, 32'h44, "R3 load C cur");
      push_wr(8'h13, 32'h01, "R3 load C next");
      push_wr(8'h14, 32'h00100080, "R3 load C token");
      push_xa(16'd8, 16'd8, 3'b101, "R8 fatal");
      push_wr(8'h14, 32'h00080058, "R8 halted overlay");
      push_wr(8'h45, 32'h00080058, "R8 writeback C");

      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R12 mem_req in reset", {31'h0, mem_req}, 32'h0);
      check("R12 xact_req in reset", {31'h0, xact_req}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 idle after reset", {31'h0, mem_req | xact_req}, 32'h0);
      run = 1'b1;

      cyc = 0;
      while ((exp_wr.size() > 0 || exp_xa.size() > 0) && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
      if (cyc >= 20000) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d pending expected=0", exp_wr.size() + exp_xa.size());
      end
      // further laps: halted QH0/QH2 and idle QH1 must stay silent
      repeat (600) @(negedge clk);

      exp_rd = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h40, 8'h41, 8'h20, 8'h21, 8'h22};
      for (int i = 0; i < 10; i++)
         check($sformatf("R1 R3 read order %0d", i), {24'h0, rd_log[i]}, {24'h0, exp_rd[i]});
      check("R7 descriptor A token", mem[8'h41], 32'h00000020);
      check("R8 descriptor C token", mem[8'h45], 32'h00080058);
      check("R9 halted QH0 pointer kept", mem[8'h12], 32'h44);
      check("R9 halted QH2 token kept", mem[8'h34], 32'h000400C0);
      check("R9 halted QH2 cur kept", mem[8'h32], 32'h50);
      check("R10 idle QH1 cur kept", mem[8'h22], 32'h0);
      check("R10 idle QH1 token kept", mem[8'h24], 32'h0);
      check("R2 R4 no stray requests", {31'h0, xact_req}, 32'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule